// File: doc/BRIEF.md
# Segment Descriptor Restore Unit

This block carries out the system-management operation that loads one segment register together with its hidden descriptor cache from a 10-byte memory image. An upstream decoder presents a request holding the 3-bit segment register number from the reg field of the ModR/M byte and the whole 80-bit operand. The processor-state inputs are sampled in the same cycle. The unit first decides whether the operation may run. If it may, it splits the operand into a selector, a 32-bit base, a byte-granular effective limit and the attribute bits. It then commits them to the addressed slot of its six-entry segment file. If it may not, it reports an undefined-opcode fault with a cause code and leaves every slot untouched.

Every request occupies the unit for a fixed ten clocks, whatever its outcome. The request side is a valid/ready channel. `req_ready` is high exactly when the unit is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the unit is busy, `req_ready` is low and anything on the request pins has no effect, so an upstream stage simply holds its request until ready returns. The result side has no back-pressure: one `done` or `fault` strobe of a single cycle closes each request. The segment file is observed through a combinational read port.

Top module: `sdr_restore_unit`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request is accepted only on an edge with `req_valid` and `req_ready` both high. Request pins driven while busy alter neither the outcome nor the slots.
- R2: After acceptance, `busy` is high for exactly 10 cycles. In the cycle after it falls, exactly one of `done` or `fault` is high, for one cycle.
- R3: The operation is permitted only if all four conditions hold: `st_cpl` is 0, `st_smi_en` is 1, `st_region_size` is nonzero, and either `st_in_smm` or `st_smm_access` is 1. Otherwise `fault` pulses with `fault_cause` = 1 and no slot changes. This check has the highest priority.
- R4: When permitted, a segment number of 6 or 7 gives `fault` with `fault_cause` = 2 and no slot change.
- R5: When permitted, segment number 1 (the code segment) gives `fault` with `fault_cause` = 3 and no slot change.
- R6: On success, the slot selector is operand bits 79:64 (the word at byte offset +8).
- R7: On success, the slot base is {operand[63:56], operand[39:32], operand[31:16]}.
- R8: On success, `rd_attr` holds these fields: [11] present = op[47], [10:9] privilege = op[46:45], [8] descriptor type = op[44], [7:4] type = op[43:40], [3] granularity = op[55], [2] default size = op[54], [1] reserved = op[53], [0] available = op[52].
- R9: The raw 20-bit limit is {op[51:48], op[15:0]}. With granularity 1, `rd_limit` is that limit followed by twelve one bits. With granularity 0, it is the limit zero-extended to 32 bits.
- R10: All fields of the target slot change on one edge. That edge is the one that raises `done`, so the new contents are readable in the `done` cycle.
- R11: After reset, the unit is idle with `req_ready` high and no strobe, and every slot reads as all zeros. `fault_cause` is 0 whenever `fault` is low. A `rd_idx` of 6 or 7 reads zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_sreg | input | 3 | Target segment register number |
| req_operand | input | 80 | 10-byte memory image, byte offset +0 in bits 15:0 |
| st_cpl | input | 2 | Current privilege level |
| st_smi_en | input | 1 | System-management interrupt enable |
| st_smm_access | input | 1 | System-management access enable outside SMM |
| st_in_smm | input | 1 | Processor is in system-management mode |
| st_region_size | input | 32 | Size of the system-management address region |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success strobe |
| fault | output | 1 | One-cycle undefined-opcode fault strobe |
| fault_cause | output | 2 | 1 permission, 2 bad index, 3 code segment |
| rd_idx | input | 3 | Segment file read index |
| rd_selector | output | 16 | Selector of the read slot |
| rd_base | output | 32 | Base of the read slot |
| rd_limit | output | 32 | Effective limit of the read slot |
| rd_attr | output | 12 | Attributes of the read slot |

## Verification
The embedded properties rely on two things: the processor-state and request inputs matter only on the accepting edge, and the latched request stays fixed until the closing strobe. They assume nothing about these pins at other times. The stimulus changes the state inputs freely between requests. It also raises `req_valid` with unrelated data during busy windows, so the ignore rule and the hold property are both exercised. Every request waits for `req_ready`, so no accepted request overlaps another. The expected outcome for each one is queued when it is issued.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       code_data;
    logic [3:0] kind;
    logic       gran;
    logic       dsize;
    logic       rsvd;
    logic       avl;
  } seg_attr_t;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] limit;
    seg_attr_t   attr;
  } seg_slot_t;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_PERM    = 2'd1,
    CAUSE_BADIDX  = 2'd2,
    CAUSE_CODESEG = 2'd3
  } fault_cause_e;

endpackage

// File: rtl/sdr_permit.sv
module sdr_permit
  import sdr_pkg::*;
#(
  parameter int SREG_W    = 3,
  parameter int SEG_COUNT = 6,
  parameter int CS_INDEX  = 1,
  parameter int SIZE_W    = 32
) (
  input  logic [1:0]        cpl,
  input  logic              smi_en,
  input  logic              smm_access,
  input  logic              in_smm,
  input  logic [SIZE_W-1:0] region_size,
  input  logic [SREG_W-1:0] sreg,
  output fault_cause_e      cause
);
  localparam logic [SREG_W-1:0] CS_CODE  = SREG_W'(CS_INDEX);
  localparam logic [SREG_W-1:0] LAST_IDX = SREG_W'(SEG_COUNT - 1);

  logic state_ok;
  logic idx_ok;

  always_comb begin
    state_ok = (cpl == 2'd0) && smi_en && (region_size != '0) &&
               (in_smm || smm_access);
    idx_ok   = (sreg <= LAST_IDX);
    if (!state_ok)             cause = CAUSE_PERM;
    else if (!idx_ok)          cause = CAUSE_BADIDX;
    else if (sreg == CS_CODE)  cause = CAUSE_CODESEG;
    else                       cause = CAUSE_NONE;
  end

endmodule

// File: rtl/sdr_unpack.sv
module sdr_unpack
  import sdr_pkg::*;
(
  input  logic [79:0] operand,
  output seg_slot_t   slot
);
  localparam int WORD_W = 16;
  localparam int LIM_W  = 20;
  localparam int PAGE_W = 12;

  logic [WORD_W-1:0] w_lim_lo, w_base_lo, w_acc, w_hi, w_sel;
  logic [LIM_W-1:0]  raw_limit;

  always_comb begin
    w_lim_lo  = operand[0*WORD_W +: WORD_W];
    w_base_lo = operand[1*WORD_W +: WORD_W];
    w_acc     = operand[2*WORD_W +: WORD_W];
    w_hi      = operand[3*WORD_W +: WORD_W];
    w_sel     = operand[4*WORD_W +: WORD_W];

    raw_limit = {w_hi[3:0], w_lim_lo};

    slot.sel            = w_sel;
    slot.base           = {w_hi[15:8], w_acc[7:0], w_base_lo};
    slot.attr.present   = w_acc[15];
    slot.attr.dpl       = w_acc[14:13];
    slot.attr.code_data = w_acc[12];
    slot.attr.kind      = w_acc[11:8];
    slot.attr.gran      = w_hi[7];
    slot.attr.dsize     = w_hi[6];
    slot.attr.rsvd      = w_hi[5];
    slot.attr.avl       = w_hi[4];
    if (w_hi[7]) slot.limit = {raw_limit, {PAGE_W{1'b1}}};
    else         slot.limit = {{(32-LIM_W){1'b0}}, raw_limit};
  end

endmodule

// File: rtl/sdr_seq.sv
module sdr_seq #(
  parameter int OP_CLOCKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic outcome_ok,
  output logic busy,
  output logic last,
  output logic done,
  output logic fault
);
  localparam int CW = $clog2(OP_CLOCKS + 1);
  localparam logic [CW-1:0] CNT_END = CW'(OP_CLOCKS);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign last = (cnt == CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= last && outcome_ok;
      fault <= last && !outcome_ok;
      if (start && !busy) cnt <= CW'(1);
      else if (last)      cnt <= '0;
      else if (busy)      cnt <= cnt + CW'(1);
    end
  end

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_END); // R2
  AST_STROBE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && $past(busy))); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault})); // R2

endmodule

// File: rtl/sdr_restore_unit.sv
module sdr_restore_unit
  import sdr_pkg::*;
#(
  parameter int SEG_COUNT = 6,
  parameter int CS_INDEX  = 1,
  parameter int OP_CLOCKS = 10,
  parameter int SIZE_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_sreg,
  input  logic [79:0]       req_operand,
  input  logic [1:0]        st_cpl,
  input  logic              st_smi_en,
  input  logic              st_smm_access,
  input  logic              st_in_smm,
  input  logic [SIZE_W-1:0] st_region_size,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_cause,
  input  logic [2:0]        rd_idx,
  output logic [15:0]       rd_selector,
  output logic [31:0]       rd_base,
  output logic [31:0]       rd_limit,
  output logic [11:0]       rd_attr
);
  localparam int SREG_W = 3;
  localparam logic [SREG_W-1:0] LAST_IDX = SREG_W'(SEG_COUNT - 1);

  fault_cause_e req_cause, lat_cause;
  seg_slot_t    req_slot, lat_slot, rd_slot;
  logic [SREG_W-1:0] lat_sreg;
  logic accept, last;
  logic [SEG_COUNT-1:0] slot_hit;
  seg_slot_t [SEG_COUNT-1:0] slot_q;

  sdr_permit #(
    .SREG_W(SREG_W), .SEG_COUNT(SEG_COUNT),
    .CS_INDEX(CS_INDEX), .SIZE_W(SIZE_W)
  ) u_permit (
    .cpl(st_cpl), .smi_en(st_smi_en), .smm_access(st_smm_access),
    .in_smm(st_in_smm), .region_size(st_region_size),
    .sreg(req_sreg), .cause(req_cause)
  );

  sdr_unpack u_unpack (
    .operand(req_operand), .slot(req_slot)
  );

  sdr_seq #(.OP_CLOCKS(OP_CLOCKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .outcome_ok(lat_cause == CAUSE_NONE),
    .busy(busy), .last(last), .done(done), .fault(fault)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_sreg  <= '0;
      lat_cause <= CAUSE_NONE;
      lat_slot  <= '0;
    end else if (accept) begin
      lat_sreg  <= req_sreg;
      lat_cause <= req_cause;
      lat_slot  <= req_slot;
    end
  end

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_hit
    assign slot_hit[i] = last && (lat_cause == CAUSE_NONE) &&
                         (lat_sreg == SREG_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int i = 0; i < SEG_COUNT; i++) begin
        if (slot_hit[i]) slot_q[i] <= lat_slot;
      end
    end
  end

  always_comb begin
    rd_slot = '0;
    if (rd_idx <= LAST_IDX) rd_slot = slot_q[rd_idx];
    rd_selector = rd_slot.sel;
    rd_base     = rd_slot.base;
    rd_limit    = rd_slot.limit;
    rd_attr     = rd_slot.attr;
    fault_cause = fault ? lat_cause : CAUSE_NONE;
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_sreg) && $stable(lat_cause) && $stable(lat_slot))); // R1
  AST_FAULT_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (slot_q == $past(slot_q))); // R3
  AST_CODESEG_NEVER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_sreg != SREG_W'(CS_INDEX) && lat_sreg <= LAST_IDX)); // R5
  AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slot_q[lat_sreg] == lat_slot)); // R10
  AST_CAUSE_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_cause == 2'd0)); // R11

endmodule

// File: tb/sdr_restore_unit_bench.sv
`timescale 1ns/1ps
module sdr_restore_unit_bench;

  typedef struct {
    logic        is_fault;
    logic [1:0]  cause;
    logic [2:0]  idx;
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] lim;
    logic [11:0] attr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_sreg = '0;
  logic [79:0] req_operand = '0;
  logic [1:0] st_cpl = '0;
  logic st_smi_en = 1'b0, st_smm_access = 1'b0, st_in_smm = 1'b0;
  logic [31:0] st_region_size = '0;
  logic busy, done, fault;
  logic [1:0] fault_cause;
  logic [2:0] rd_idx = '0;
  logic [15:0] rd_selector;
  logic [31:0] rd_base, rd_limit;
  logic [11:0] rd_attr;

  int checks = 0;
  int fails = 0;
  int busy_cnt = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [15:0] sh_sel [6];
  logic [31:0] sh_base [6];
  logic [31:0] sh_lim [6];
  logic [11:0] sh_attr [6];

  always #4 clk = ~clk;

  sdr_restore_unit u_sdr_restore_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sreg(req_sreg), .req_operand(req_operand), .st_cpl(st_cpl),
    .st_smi_en(st_smi_en), .st_smm_access(st_smm_access), .st_in_smm(st_in_smm),
    .st_region_size(st_region_size), .busy(busy), .done(done), .fault(fault),
    .fault_cause(fault_cause), .rd_idx(rd_idx), .rd_selector(rd_selector),
    .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_file(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.1;
      if (i < 6) begin
        chk(rd_selector == sh_sel[i], {req, " R6 selector"}, 32'(rd_selector), 32'(sh_sel[i]));
        chk(rd_base == sh_base[i], {req, " R7 base"}, rd_base, sh_base[i]);
        chk(rd_limit == sh_lim[i], {req, " R9 limit"}, rd_limit, sh_lim[i]);
        chk(rd_attr == sh_attr[i], {req, " R8 attr"}, 32'(rd_attr), 32'(sh_attr[i]));
      end else begin
        chk({rd_selector, rd_base, rd_limit, rd_attr} == '0, "R11 unused index reads zero",
            rd_base, 32'd0);
      end
    end
  endtask

  // Driver: issues one request and queues the outcome the requirements predict.
  task automatic issue(input logic [2:0] sreg, input logic [79:0] op,
                       input logic [1:0] cpl, input logic smi, input logic acc,
                       input logic smm, input logic [31:0] size, input bit noise);
    exp_t e;
    logic [19:0] raw;
    bit permitted;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_sreg = sreg; req_operand = op; st_cpl = cpl; st_smi_en = smi;
    st_smm_access = acc; st_in_smm = smm; st_region_size = size;
    req_valid = 1'b1;
    permitted = (cpl == 0) && smi && (size != 0) && (smm || acc);
    e.idx = sreg;
    if (!permitted)     e.cause = 2'd1;
    else if (sreg > 5)  e.cause = 2'd2;
    else if (sreg == 1) e.cause = 2'd3;
    else                e.cause = 2'd0;
    e.is_fault = (e.cause != 0);
    e.sel  = op[79:64];
    e.base = {op[63:56], op[39:32], op[31:16]};
    raw    = {op[51:48], op[15:0]};
    e.lim  = op[55] ? {raw, 12'hFFF} : {12'h000, raw};
    e.attr = {op[47], op[46:45], op[44], op[43:40], op[55], op[54], op[53], op[52]};
    sb.push_back(e);
    @(negedge clk);
    chk(busy && !req_ready, "R1 busy after accept", 32'(busy), 32'd1);
    req_valid = 1'b0;
    if (noise) begin
      // R1: request pins driven during busy must be ignored
      req_valid = 1'b1; req_sreg = 3'd0; req_operand = ~op;
      st_cpl = 2'd0; st_smi_en = 1'b1; st_smm_access = 1'b1; st_region_size = 32'h1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end else begin
      st_cpl = 2'($urandom); st_smi_en = 1'($urandom);
    end
  endtask

  // Monitor: pops expected results as strobes appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done || fault) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", {30'd0, done, fault}, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(busy_cnt == 10, "R2 busy length", 32'(busy_cnt), 32'd10);
          chk(fault == e.is_fault && done == !e.is_fault, "R2 strobe kind",
              {30'd0, done, fault}, {30'd0, !e.is_fault, e.is_fault});
          chk(fault_cause == e.cause,
              e.cause == 1 ? "R3 cause" : e.cause == 2 ? "R4 cause" : e.cause == 3 ? "R5 cause" : "R11 cause",
              32'(fault_cause), 32'(e.cause));
          if (!e.is_fault) begin
            sh_sel[e.idx] = e.sel; sh_base[e.idx] = e.base;
            sh_lim[e.idx] = e.lim; sh_attr[e.idx] = e.attr;
          end
          check_file(e.is_fault ? "R3/R4/R5 slots unchanged:" : "R10 commit:");
        end
        busy_cnt = 0;
      end
      if (busy) busy_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [79:0] op;
    for (int i = 0; i < 6; i++) begin
      sh_sel[i] = '0; sh_base[i] = '0; sh_lim[i] = '0; sh_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R11 idle after reset", {30'd0, req_ready, busy}, 32'd2);
    chk(!done && !fault && fault_cause == 0, "R11 no strobe after reset",
        {29'd0, done, fault, |fault_cause}, 32'd0);
    check_file("R11 reset:");

    // legal loads, granularity 0 and 1
    issue(3'd0, 80'h1234_5600_8A9B_CDEF_4321, 2'd0, 1, 0, 1, 32'h100, 0);
    issue(3'd2, 80'hBEEF_A7F5_F3C4_1111_2222, 2'd0, 1, 1, 0, 32'h1, 1);
    issue(3'd3, 80'h0008_FF0F_FFFF_FFFF_FFFF, 2'd0, 1, 1, 1, 32'h8000_0000, 0);
    issue(3'd4, 80'h0010_0080_0000_0000_0000, 2'd0, 1, 0, 1, 32'h4, 0);
    issue(3'd5, 80'hFFFF_2A30_9355_6677_0FFF, 2'd0, 1, 1, 0, 32'h10, 0);
    // R3: each condition failing alone
    issue(3'd0, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 2'd3, 1, 1, 1, 32'h100, 0);
    issue(3'd0, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 2'd0, 0, 1, 1, 32'h100, 0);
    issue(3'd0, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 2'd0, 1, 1, 1, 32'h0, 1);
    issue(3'd0, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 2'd0, 1, 0, 0, 32'h100, 0);
    // R5 code segment; R4 bad indices; priority of R3
    issue(3'd1, 80'h5555_5555_5555_5555_5555, 2'd0, 1, 1, 1, 32'h100, 0);
    issue(3'd6, 80'h5555_5555_5555_5555_5555, 2'd0, 1, 1, 1, 32'h100, 0);
    issue(3'd7, 80'h5555_5555_5555_5555_5555, 2'd0, 1, 0, 1, 32'h100, 1);
    issue(3'd7, 80'h5555_5555_5555_5555_5555, 2'd1, 1, 0, 1, 32'h100, 0);
    issue(3'd1, 80'h5555_5555_5555_5555_5555, 2'd0, 1, 0, 0, 32'h100, 0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      op = {$urandom, $urandom, 16'($urandom)};
      issue(3'($urandom), op, ($urandom % 3 == 0) ? 2'($urandom) : 2'd0,
            ($urandom % 5 != 0), 1'($urandom), 1'($urandom),
            ($urandom % 6 == 0) ? 32'd0 : $urandom, ($urandom % 4 == 0));
    end
    while (sb.size() != 0 || busy) @(negedge clk);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule